// File: doc/BRIEF.md
# Synchronous Clock-Stop Gating Controller

This block sits between the clock sources of a board-level clock generator and its output buffers. It gates the stoppable clock copies in response to two active-low stop requests and never lets a shortened high or low phase reach an output. A CPU-side stop request controls the stoppable CPU clock copy, an interrupt-controller reference copy and a bank of buffered memory clock copies. A PCI-side stop request controls the stoppable PCI clock copies. One free-running copy in each group always passes its source clock.

Each gated output has its own enable register. That register updates on the falling edge of the output's own source clock. The enable can therefore change only while the clock is low, so a clock that is running finishes its current high phase before it parks low, and a parked clock restarts with a full high phase. The CPU stop request first passes a two-stage synchroniser on the CPU clock. The PCI stop request is taken as synchronous to the free-running PCI clock and is sampled once on its rising edge.

A strap input is captured while reset is asserted. In one mode the PCI stop request is honoured. In the other mode the same shared pin carries a copy of the reference clock and PCI stopping is disabled.

Top module: `clkstop_ctrl`

## Requirements
- R1: The high phase of `cpu_gated_o` that begins at a rising edge of `clk_cpu_i` is present exactly when `cpu_stop_n_i` was 1 at the rising edge of `clk_cpu_i` two edges earlier. When the request changes between edges, this gives a 2 to 3 cycle delay to both stop and restart.
- R2: A stoppable output never rises while its source clock is low and never falls while its source clock is high. It is therefore low during every low phase of its source clock and is never truncated.
- R3: The CPU stop request passes a two-flop synchroniser clocked by `clk_cpu_i`. The synchronised value is taken up at each falling edge of `clk_mem_i` for every bit of `mem_gated_o`, and at each falling edge of `clk_ref_i` for `apic_o`. The following high phase of that clock is present exactly when the captured value is 1.
- R4: `cpu_free_o`, `mem_free_o` and `pci_free_o` always equal `clk_cpu_i`, `clk_mem_i` and `clk_pci_i`, including during reset, whatever the stop inputs do.
- R5: In mode 0, `pci_stop_n_i` is sampled on each rising edge of `clk_pci_i`. During the next `clk_pci_i` cycle, all bits of `pci_gated_o` toggle if the sample was 1 and stay at 0 if it was 0.
- R6: `mode_strap_i` is captured on every rising edge of `clk_pci_i` while `rst_i` is 1 and is held after reset deasserts. With the strap at 0, `ref_share_o` stays low. With the strap at 1, `pci_stop_n_i` has no effect and `ref_share_o` carries `clk_ref_i` from the first full `clk_ref_i` cycle after reset.
- R7: While `rst_i` (active high, synchronous in each clock domain) is 1, every stoppable output and `ref_share_o` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu_i | input | 1 | CPU source clock |
| clk_pci_i | input | 1 | PCI source clock |
| clk_ref_i | input | 1 | Reference source clock |
| clk_mem_i | input | 1 | Memory buffer input clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cpu_stop_n_i | input | 1 | Active-low CPU-side stop request, asynchronous |
| pci_stop_n_i | input | 1 | Active-low PCI-side stop request, synchronous to clk_pci_i |
| mode_strap_i | input | 1 | Shared-pin mode strap: 0 stop input, 1 reference output |
| cpu_free_o | output | 1 | Free-running CPU copy |
| cpu_gated_o | output | 1 | Stoppable CPU copy |
| apic_o | output | 1 | Stoppable interrupt-controller reference copy |
| mem_free_o | output | 1 | Free-running memory copy |
| mem_gated_o | output | MEM_COPIES | Stoppable memory copies |
| pci_free_o | output | 1 | Free-running PCI copy |
| pci_gated_o | output | PCI_COPIES | Stoppable PCI copies |
| ref_share_o | output | 1 | Reference copy on the shared pin (mode 1 only) |

## Verification
The assertions assume that `pci_stop_n_i` changes only away from rising edges of `clk_pci_i`. They also assume that reset is held for several cycles of the slowest clock, and that the strap does not change around the release of reset. The bench keeps within these assumptions. It moves the stop requests and reset mid-cycle in their own domains and places the reference and PCI clock edges at fractional offsets, so they never line up with CPU edges. It sets the strap before each reset and changes it afterwards only to show that the change is ignored. The memory and reference gates cross from the CPU domain. For that reason the bench holds each stop level for at least one CPU cycle before changing it.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    localparam int MEM_COPIES_DEF = 12;
    localparam int PCI_COPIES_DEF = 5;
    localparam int SYNC_DEPTH     = 2;

    typedef enum logic {
        MODE_PCI_STOP = 1'b0,
        MODE_REF_OUT  = 1'b1
    } strap_mode_e;

    typedef struct packed {
        logic cpu;
        logic pci;
    } run_req_t;

    function automatic logic pci_stop_honoured(strap_mode_e m);
        return m == MODE_PCI_STOP;
    endfunction

    function automatic logic ref_share_enabled(strap_mode_e m);
        return m == MODE_REF_OUT;
    endfunction

endpackage

// File: rtl/cs_sync.sv
module cs_sync
    import clkstop_pkg::*;
#(
    parameter int DEPTH = SYNC_DEPTH
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    localparam int TOP = DEPTH - 1;

    logic [TOP:0] chain_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q <= '0;
                else       chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q <= '0;
                else       chain_q <= {chain_q[TOP-1:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[TOP];

endmodule

// File: rtl/cs_gate.sv
module cs_gate #(
    parameter int COPIES = 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              run_i,
    output logic              en_o,
    output logic [COPIES-1:0] clk_o
);
    logic en_q;

    // Enable moves only on the falling edge, i.e. while clk_i is low.
    always_ff @(negedge clk_i) begin
        if (rst_i) en_q <= 1'b0;
        else       en_q <= run_i;
    end

    assign en_o = en_q;

    generate
        for (genvar g = 0; g < COPIES; g++) begin : g_copy
            assign clk_o[g] = clk_i & en_q;
        end
    endgenerate

endmodule

// File: rtl/cs_pci_ctl.sv
module cs_pci_ctl
    import clkstop_pkg::*;
(
    input  logic        clk_pci_i,
    input  logic        rst_i,
    input  logic        stop_n_i,
    input  logic        strap_i,
    output logic        run_o,
    output strap_mode_e mode_o
);
    strap_mode_e mode_q;
    logic        run_q;

    always_ff @(posedge clk_pci_i) begin
        if (rst_i) begin
            mode_q <= strap_mode_e'(strap_i);
            run_q  <= 1'b0;
        end else begin
            run_q  <= pci_stop_honoured(mode_q) ? stop_n_i : 1'b1;
        end
    end

    assign run_o  = run_q;
    assign mode_o = mode_q;

    // R6: strap stays frozen once reset is gone
    a_r6_strap_held: assert property (@(posedge clk_pci_i) disable iff (rst_i)
        1'b1 |=> $stable(mode_q));

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int MEM_COPIES = MEM_COPIES_DEF,
    parameter int PCI_COPIES = PCI_COPIES_DEF
) (
    input  logic                  clk_cpu_i,
    input  logic                  clk_pci_i,
    input  logic                  clk_ref_i,
    input  logic                  clk_mem_i,
    input  logic                  rst_i,
    input  logic                  cpu_stop_n_i,
    input  logic                  pci_stop_n_i,
    input  logic                  mode_strap_i,
    output logic                  cpu_free_o,
    output logic                  cpu_gated_o,
    output logic                  apic_o,
    output logic                  mem_free_o,
    output logic [MEM_COPIES-1:0] mem_gated_o,
    output logic                  pci_free_o,
    output logic [PCI_COPIES-1:0] pci_gated_o,
    output logic                  ref_share_o
);
    run_req_t    run;
    strap_mode_e mode;
    logic        cpu_en, apic_en, mem_en, pci_en, share_en;

    // Free-running copies
    assign cpu_free_o = clk_cpu_i;
    assign mem_free_o = clk_mem_i;
    assign pci_free_o = clk_pci_i;

    cs_sync #(.DEPTH(SYNC_DEPTH)) u_cpu_sync (
        .clk_i (clk_cpu_i),
        .rst_i (rst_i),
        .d_i   (cpu_stop_n_i),
        .q_o   (run.cpu)
    );

    cs_pci_ctl u_pci_ctl (
        .clk_pci_i (clk_pci_i),
        .rst_i     (rst_i),
        .stop_n_i  (pci_stop_n_i),
        .strap_i   (mode_strap_i),
        .run_o     (run.pci),
        .mode_o    (mode)
    );

    cs_gate #(.COPIES(1)) u_cpu_gate (
        .clk_i (clk_cpu_i), .rst_i (rst_i), .run_i (run.cpu),
        .en_o  (cpu_en),    .clk_o (cpu_gated_o)
    );

    cs_gate #(.COPIES(1)) u_apic_gate (
        .clk_i (clk_ref_i), .rst_i (rst_i), .run_i (run.cpu),
        .en_o  (apic_en),   .clk_o (apic_o)
    );

    cs_gate #(.COPIES(MEM_COPIES)) u_mem_gate (
        .clk_i (clk_mem_i), .rst_i (rst_i), .run_i (run.cpu),
        .en_o  (mem_en),    .clk_o (mem_gated_o)
    );

    cs_gate #(.COPIES(PCI_COPIES)) u_pci_gate (
        .clk_i (clk_pci_i), .rst_i (rst_i), .run_i (run.pci),
        .en_o  (pci_en),    .clk_o (pci_gated_o)
    );

    cs_gate #(.COPIES(1)) u_share_gate (
        .clk_i (clk_ref_i), .rst_i (rst_i), .run_i (ref_share_enabled(mode)),
        .en_o  (share_en),  .clk_o (ref_share_o)
    );

    // Cycles since reset, saturating; used only by the latency check.
    logic [1:0] since_rst_q;
    always_ff @(posedge clk_cpu_i) begin
        if (rst_i)                 since_rst_q <= 2'd0;
        else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
    end

    // R3: synchronised request is the stop input two CPU edges back
    a_r3_sync_two_stage: assert property (@(posedge clk_cpu_i) disable iff (rst_i)
        (since_rst_q >= 2'd2) |-> (run.cpu == $past(cpu_stop_n_i, 2)));

    // R1: CPU gate enable seen at a rising edge matches the synchroniser output
    a_r1_cpu_gate_tracks: assert property (@(posedge clk_cpu_i) disable iff (rst_i)
        cpu_en == run.cpu);

    // R5: PCI gate enable one cycle after a sample equals that sample
    a_r5_pci_next_cycle: assert property (@(posedge clk_pci_i) disable iff (rst_i)
        (mode == MODE_PCI_STOP) |=> (pci_en == $past(pci_stop_n_i)));

    // R6: in reference-output mode the PCI copies are never stopped
    a_r6_ref_mode_no_stop: assert property (@(posedge clk_pci_i) disable iff (rst_i)
        (mode == MODE_REF_OUT) |=> pci_en);

    // R6: shared reference copy only runs in reference-output mode
    a_r6_share_mode_only: assert property (@(posedge clk_ref_i) disable iff (rst_i)
        share_en |-> (mode == MODE_REF_OUT));

    // R3: memory and interrupt-controller enables only run while CPU domain runs or just stopped
    a_r3_mem_apic_quiet: assert property (@(posedge clk_cpu_i) disable iff (rst_i)
        (since_rst_q == 2'd3 && !run.cpu && !$past(run.cpu) && !$past(run.cpu, 2)
         && !$past(run.cpu, 3)) |-> (!mem_en && !apic_en));

endmodule

// File: tb/clkstop_ctrl_tb.sv
`timescale 1ns/10ps
module clkstop_ctrl_tb;
    import clkstop_pkg::*;

    localparam int MEMC = MEM_COPIES_DEF;
    localparam int PCIC = PCI_COPIES_DEF;

    logic clk_cpu = 1'b0, clk_mem = 1'b0, clk_ref = 1'b0, clk_pci = 1'b0;
    logic rst = 1'b1, cpu_stop_n = 1'b1, pci_stop_n = 1'b1, strap = 1'b0;

    logic            cpu_free_o, cpu_gated_o, apic_o, mem_free_o, pci_free_o, ref_share_o;
    logic [MEMC-1:0] mem_gated_o;
    logic [PCIC-1:0] pci_gated_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    clkstop_ctrl u_dut (
        .clk_cpu_i (clk_cpu), .clk_pci_i (clk_pci), .clk_ref_i (clk_ref), .clk_mem_i (clk_mem),
        .rst_i (rst), .cpu_stop_n_i (cpu_stop_n), .pci_stop_n_i (pci_stop_n),
        .mode_strap_i (strap),
        .cpu_free_o (cpu_free_o), .cpu_gated_o (cpu_gated_o), .apic_o (apic_o),
        .mem_free_o (mem_free_o), .mem_gated_o (mem_gated_o), .pci_free_o (pci_free_o),
        .pci_gated_o (pci_gated_o), .ref_share_o (ref_share_o)
    );

    // 250 MHz CPU clock; memory clock is the CPU clock delayed by 1 ns
    always #2 clk_cpu = ~clk_cpu;
    initial begin #1; forever #2 clk_mem = ~clk_mem; end
    initial begin #0.5; forever #7 clk_ref = ~clk_ref; end
    initial begin #0.25; forever #15 clk_pci = ~clk_pci; end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    // ---------------- reference model ----------------
    bit cq[$] = '{1'b0, 1'b0};      // CPU-side request history, newest first
    bit m_en_cpu = 0, m_en_mem = 0, m_en_apic = 0;
    bit m_run_pci = 0, m_mode = 0, m_en_pci = 0, m_en_share = 0;

    always @(posedge clk_cpu) begin
        if (rst) cq = '{1'b0, 1'b0};
        else begin
            cq.push_front(cpu_stop_n);
            void'(cq.pop_back());
        end
    end
    always @(negedge clk_cpu) m_en_cpu  = rst ? 1'b0 : cq[1];
    always @(negedge clk_mem) m_en_mem  = rst ? 1'b0 : cq[1];
    always @(negedge clk_ref) begin
        m_en_apic  = rst ? 1'b0 : cq[1];
        m_en_share = rst ? 1'b0 : m_mode;
    end
    always @(posedge clk_pci) begin
        if (rst) begin
            m_run_pci = 1'b0;
            m_mode    = strap;
        end else begin
            m_run_pci = m_mode ? 1'b1 : pci_stop_n;
        end
    end
    always @(negedge clk_pci) m_en_pci = rst ? 1'b0 : m_run_pci;

    // ---------------- per-clock comparison ----------------
    always @(posedge clk_cpu) begin
        #1;
        chk(rst ? "R7 cpu_gated" : "R1 cpu_gated", 32'(cpu_gated_o), 32'(m_en_cpu));
        chk("R4 cpu_free", 32'(cpu_free_o), 32'd1);
    end
    always @(negedge clk_cpu) begin
        #1;
        chk("R2 cpu_gated low phase", 32'(cpu_gated_o), 32'd0);
        chk("R4 cpu_free low", 32'(cpu_free_o), 32'd0);
    end
    always @(posedge clk_mem) begin
        #1;
        chk(rst ? "R7 mem_gated" : "R3 mem_gated", 32'(mem_gated_o), 32'({MEMC{m_en_mem}}));
        chk("R4 mem_free", 32'(mem_free_o), 32'd1);
    end
    always @(negedge clk_mem) begin
        #1;
        chk("R2 mem_gated low phase", 32'(mem_gated_o), 32'd0);
    end
    always @(posedge clk_ref) begin
        #1;
        chk(rst ? "R7 apic" : "R3 apic", 32'(apic_o), 32'(m_en_apic));
        chk(rst ? "R7 ref_share" : "R6 ref_share", 32'(ref_share_o), 32'(m_en_share));
    end
    always @(posedge clk_pci) begin
        #2;
        chk(rst ? "R7 pci_gated" : "R5 pci_gated", 32'(pci_gated_o), 32'({PCIC{m_en_pci}}));
        chk("R4 pci_free", 32'(pci_free_o), 32'd1);
    end
    always @(negedge clk_pci) begin
        #2;
        chk("R2 pci_gated low phase", 32'(pci_gated_o), 32'd0);
    end

    // R2: runt detector on the stoppable CPU copy
    always @(posedge cpu_gated_o) chk("R2 cpu rise with clock", 32'(clk_cpu), 32'd1);
    always @(negedge cpu_gated_o) chk("R2 cpu fall with clock", 32'(clk_cpu), 32'd0);
    always @(posedge pci_gated_o[0]) chk("R2 pci rise with clock", 32'(clk_pci), 32'd1);

    // ---------------- stimulus ----------------
    task automatic cpu_cycles(input int n);
        repeat (n) @(posedge clk_cpu);
        #1.5;
    endtask

    task automatic set_cpu_stop(input logic v, input int hold);
        cpu_stop_n = v;
        cpu_cycles(hold);
    endtask

    task automatic set_pci_stop(input logic v, input int hold);
        @(posedge clk_pci);
        #5;
        pci_stop_n = v;
        repeat (hold) @(posedge clk_pci);
    endtask

    initial begin
        // Mode 0, reset
        strap = 1'b0;
        rst   = 1'b1;
        cpu_cycles(60);
        rst = 1'b0;
        cpu_cycles(20);

        // R1/R3: CPU stop pulses of different widths
        set_cpu_stop(1'b0, 1);
        set_cpu_stop(1'b1, 10);
        set_cpu_stop(1'b0, 3);
        set_cpu_stop(1'b1, 10);
        set_cpu_stop(1'b0, 20);
        set_cpu_stop(1'b1, 10);
        for (int i = 0; i < 6; i++) set_cpu_stop(i[0], 2);
        set_cpu_stop(1'b1, 12);

        // R5: PCI stop pulses
        set_pci_stop(1'b0, 1);
        set_pci_stop(1'b1, 4);
        set_pci_stop(1'b0, 5);
        set_pci_stop(1'b1, 4);

        // R6: strap changes after reset are ignored, stop still honoured
        strap = 1'b1;
        set_pci_stop(1'b0, 3);
        set_pci_stop(1'b1, 3);

        // Mode 1 via a fresh reset
        rst = 1'b1;
        cpu_cycles(60);
        rst = 1'b0;
        cpu_cycles(20);
        set_pci_stop(1'b0, 5);
        set_pci_stop(1'b1, 3);
        set_cpu_stop(1'b0, 15);
        set_cpu_stop(1'b1, 15);
        repeat (4) @(posedge clk_pci);

        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired at %0t", $time);
            report();
            $finish;
        end
    end

endmodule